// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM

This block is a synthesizable model of a pipelined synchronous static RAM with a two-bit burst sequencer. Every control, address and write-data input is taken on the rising clock edge. A read result reaches the data output one clock edge after the access is accepted, through a dedicated output register. A chip-level user starts an access with either of two address strobes: a processor-side strobe and a controller-side strobe. The user can then step through up to four beats with an advance input, or hold the current beat. The beat order is interleaved or linear, chosen by a mode pin that is taken at the start of each burst.

Writes can cover the full word or selected bytes. A sleep input stops all activity while the part is deselected. Output high-impedance is shown by a drive flag. When the flag is low the data output reads as zero.

Top module: `sync_burst_sram`

## Requirements
- R1: A strobe cycle starts an access only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 are all true. Any other combination on a strobe cycle deselects the part: no access is made, the burst ends, and `rdata_drv` is 0 after the following edge.
- R2: `cs2` and the other selects are not looked at on advance or hold cycles. A burst keeps stepping while the selects show a deselect pattern.
- R3: A read accepted at clock edge n appears on `rdata` after edge n+1, with `rdata_drv`=1, provided `out_en_n` is 0.
- R4: When `ilv_mode`=1 at burst start, the low two address bits of beat k (k=0..3) are the start bits XOR k.
- R5: When `ilv_mode`=0 at burst start, beat k uses (start + k) mod 4. After the fourth beat, one more advance returns to the start address, in either mode.
- R6: `wr_all_n`=0 writes the whole word, whatever `wr_byte_n` and `byte_sel_n` hold.
- R7: With `wr_all_n`=1, `wr_byte_n`=0 and all `byte_sel_n` bits 0, the whole word is written.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, bit i of `byte_sel_n` low writes bits [8i+7:8i] and leaves the other bytes unchanged. With no byte selected, or with both write controls high, the cycle is a read.
- R9: `rdata_drv` is 0 when `out_en_n` is 1, after reset, and after any write. It stays 0 after a write burst until a read is started by a strobe.
- R10: Outside sleep, a cycle with `adv_n`=0 and both strobes high steps the burst one beat. A cycle with `adv_n`=1 and both strobes high repeats the current beat. A strobe always loads a new address, whatever `adv_n` is.
- R11: While `sleep`=1 no access takes place, write attempts included, and any burst is ended. `rdata_drv` is 0 during sleep and after exit, until a new read is started by a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs1_n | input | 1 | Select 1, active low |
| cs2 | input | 1 | Select 2, active high |
| cs3_n | input | 1 | Select 3, active low |
| astb_cpu_n | input | 1 | Processor-side address strobe, active low |
| astb_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global full-width write, active low |
| wr_byte_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | BYTES | Per-byte write selects, active low |
| out_en_n | input | 1 | Output enable, active low |
| ilv_mode | input | 1 | Burst order: 1 interleaved, 0 linear |
| sleep | input | 1 | Sleep request |
| addr | input | ADDR_W | Word address |
| wdata | input | BYTES*BYTE_W | Write data, taken in the same cycle as the write |
| rdata | output | BYTES*BYTE_W | Read data, zero while not driving |
| rdata_drv | output | 1 | High when the data output is driven |

## Verification
A write or a change of output enable can fall in the cycle right after a read. At that point the read's data is still leaving the output register while the new command is entering the input stage. The bench provokes this by issuing back-to-back strobe reads and writes, toggling `out_en_n` during a held read, and starting a read in the cycle just after a write at a related address. On every cycle a reference model computes the expected drive flag and data for the pipelined slot. A wrong overlap shows up as stale data or a driven bus where high-impedance is due.

// File: rtl/sbs_pkg.sv
// Package: shared cycle kinds and burst offset arithmetic.
// Assumes a two-bit burst field in the low address bits.
package sbs_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_SLEEP,
        OP_DESEL,
        OP_START,
        OP_ADV,
        OP_HOLD
    } op_e;

    // Offset of beat 'beat' for a burst beginning at 'first'.
    function automatic logic [1:0] beat_offset(input logic [1:0] first,
                                               input logic [1:0] beat,
                                               input logic       ilv);
        logic [1:0] r;
        if (ilv) r = first ^ beat;
        else     r = first + beat;
        return r;
    endfunction

endpackage

// File: rtl/sbs_cmd_decode.sv
// Module: classifies each cycle from the raw inputs and burst state.
// Assumes all inputs are stable around the rising edge; purely combinational.
module sbs_cmd_decode
    import sbs_pkg::*;
#(
    parameter int BYTES = 2
) (
    input  logic             sleep,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             astb_cpu_n,
    input  logic             astb_ctl_n,
    input  logic             adv_n,
    input  logic             wr_all_n,
    input  logic             wr_byte_n,
    input  logic [BYTES-1:0] byte_sel_n,
    input  logic             burst_act,
    input  logic             burst_rd,
    output op_e              op,
    output logic             acc_valid,
    output logic             acc_wr,
    output logic [BYTES-1:0] acc_be
);

    logic strobe;
    logic selected;

    // Byte enables: global write covers all lanes, byte write uses selects.
    always_comb begin
        if (!wr_all_n)       acc_be = '1;
        else if (!wr_byte_n) acc_be = ~byte_sel_n;
        else                 acc_be = '0;
        acc_wr = |acc_be;
    end

    // Cycle kind: sleep wins, then strobes, then burst continuation.
    always_comb begin
        strobe   = !astb_cpu_n || !astb_ctl_n;
        selected = !cs1_n && cs2 && !cs3_n;
        if (sleep)          op = OP_SLEEP;
        else if (strobe)    op = selected ? OP_START : OP_DESEL;
        else if (burst_act) op = adv_n ? OP_HOLD : OP_ADV;
        else                op = OP_IDLE;
    end

    // Continuation reads only belong to bursts that began (and stayed) as reads.
    always_comb begin
        unique case (op)
            OP_START:       acc_valid = 1'b1;
            OP_ADV, OP_HOLD: acc_valid = acc_wr || burst_rd;
            default:        acc_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/sbs_burst_seq.sv
// Module: holds burst base, beat count and order; forms the access address.
// Assumes ADDR_W >= 2; the low two bits are the burst field.
module sbs_burst_seq
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic              acc_wr,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              ilv_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              burst_act,
    output logic              burst_rd
);

    logic [ADDR_W-1:0] base;
    logic [1:0]        beat;
    logic              ilv;
    logic [1:0]        beat_nx;

    // Address for this cycle: new address on start, else base plus beat offset.
    always_comb begin
        beat_nx = beat + 2'd1;
        unique case (op)
            OP_START: acc_addr = addr_in;
            OP_ADV:   acc_addr = {base[ADDR_W-1:2], beat_offset(base[1:0], beat_nx, ilv)};
            default:  acc_addr = {base[ADDR_W-1:2], beat_offset(base[1:0], beat, ilv)};
        endcase
    end

    // Burst state update per cycle kind.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base      <= '0;
            beat      <= '0;
            ilv       <= 1'b1;
            burst_act <= 1'b0;
            burst_rd  <= 1'b0;
        end else begin
            unique case (op)
                OP_START: begin
                    base      <= addr_in;
                    beat      <= '0;
                    ilv       <= ilv_in;
                    burst_act <= 1'b1;
                    burst_rd  <= !acc_wr;
                end
                OP_ADV: begin
                    beat <= beat_nx;
                    if (acc_wr) burst_rd <= 1'b0;
                end
                OP_HOLD: begin
                    if (acc_wr) burst_rd <= 1'b0;
                end
                OP_SLEEP, OP_DESEL: begin
                    burst_act <= 1'b0;
                    burst_rd  <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // R10: a hold cycle keeps the burst position.
    a_r10_hold_keeps_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_HOLD) |=> ($stable(beat) && $stable(base)));

endmodule

// File: rtl/sbs_mem_pipe.sv
// Module: input stage register, byte-lane storage and output register.
// Assumes one access per cycle; storage is not reset.
module sbs_mem_pipe #(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sleep,
    input  logic                    acc_valid,
    input  logic                    acc_wr,
    input  logic [BYTES-1:0]        acc_be,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic                    q_valid,
    output logic [BYTES*BYTE_W-1:0] q_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic                    s1_v;
    logic                    s1_wr;
    logic [BYTES-1:0]        s1_be;
    logic [ADDR_W-1:0]       s1_addr;
    logic [BYTES*BYTE_W-1:0] s1_wd;

    // Input stage: capture the decided access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_wr   <= 1'b0;
            s1_be   <= '0;
            s1_addr <= '0;
            s1_wd   <= '0;
        end else begin
            s1_v    <= acc_valid;
            s1_wr   <= acc_wr;
            s1_be   <= acc_be;
            s1_addr <= acc_addr;
            s1_wd   <= wdata;
        end
    end

    // One storage array per byte lane.
    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] lane [DEPTH];

        // Lane write and registered lane read.
        always_ff @(posedge clk) begin
            if (s1_v && s1_wr && s1_be[g])
                lane[s1_addr] <= s1_wd[g*BYTE_W +: BYTE_W];
            if (s1_v && !s1_wr)
                q_data[g*BYTE_W +: BYTE_W] <= lane[s1_addr];
        end
    end

    // Output valid flag: only reads set it; sleep clears it at once.
    always_ff @(posedge clk) begin
        if (!rst_n)     q_valid <= 1'b0;
        else if (sleep) q_valid <= 1'b0;
        else            q_valid <= s1_v && !s1_wr;
    end

    // R11: sleep leaves no read result in the output register.
    a_r11_sleep_clears: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> !q_valid);

endmodule

// File: rtl/sync_burst_sram.sv
// Module: top of the pipelined burst SRAM; wires decode, sequencer and storage.
// Assumes synchronous inputs; output enable acts combinationally on the drive flag.
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 2,
    parameter int BYTE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cs1_n,
    input  logic                    cs2,
    input  logic                    cs3_n,
    input  logic                    astb_cpu_n,
    input  logic                    astb_ctl_n,
    input  logic                    adv_n,
    input  logic                    wr_all_n,
    input  logic                    wr_byte_n,
    input  logic [BYTES-1:0]        byte_sel_n,
    input  logic                    out_en_n,
    input  logic                    ilv_mode,
    input  logic                    sleep,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BYTES*BYTE_W-1:0] wdata,
    output logic [BYTES*BYTE_W-1:0] rdata,
    output logic                    rdata_drv
);

    localparam int DW = BYTES * BYTE_W;

    op_e               op;
    logic              acc_valid;
    logic              acc_wr;
    logic [BYTES-1:0]  acc_be;
    logic [ADDR_W-1:0] acc_addr;
    logic              burst_act;
    logic              burst_rd;
    logic              q_valid;
    logic [DW-1:0]     q_data;

    sbs_cmd_decode #(.BYTES(BYTES)) u_dec (
        .sleep      (sleep),
        .cs1_n      (cs1_n),
        .cs2        (cs2),
        .cs3_n      (cs3_n),
        .astb_cpu_n (astb_cpu_n),
        .astb_ctl_n (astb_ctl_n),
        .adv_n      (adv_n),
        .wr_all_n   (wr_all_n),
        .wr_byte_n  (wr_byte_n),
        .byte_sel_n (byte_sel_n),
        .burst_act  (burst_act),
        .burst_rd   (burst_rd),
        .op         (op),
        .acc_valid  (acc_valid),
        .acc_wr     (acc_wr),
        .acc_be     (acc_be)
    );

    sbs_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .op        (op),
        .acc_wr    (acc_wr),
        .addr_in   (addr),
        .ilv_in    (ilv_mode),
        .acc_addr  (acc_addr),
        .burst_act (burst_act),
        .burst_rd  (burst_rd)
    );

    sbs_mem_pipe #(.ADDR_W(ADDR_W), .BYTES(BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep     (sleep),
        .acc_valid (acc_valid),
        .acc_wr    (acc_wr),
        .acc_be    (acc_be),
        .acc_addr  (acc_addr),
        .wdata     (wdata),
        .q_valid   (q_valid),
        .q_data    (q_data)
    );

    // Output drive: registered read result gated by output enable.
    always_comb begin
        rdata_drv = q_valid && !out_en_n;
        rdata     = rdata_drv ? q_data : '0;
    end

    // R1: a deselecting strobe leaves the bus undriven one cycle later.
    a_r1_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((!astb_cpu_n || !astb_ctl_n) && !(!cs1_n && cs2 && !cs3_n) && !sleep)
        |=> ##1 !rdata_drv);

    // R9: a write never produces a driven result in its output slot.
    a_r9_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_wr) |=> ##1 !rdata_drv);

    // R2: an advance cycle keeps the burst alive whatever the selects show.
    a_r2_adv_ignores_sel: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_act && !sleep && astb_cpu_n && astb_ctl_n && !adv_n) |=> burst_act);

endmodule

// File: tb/sync_burst_sram_tb_top.sv
// Bench: cycle reference model of the SRAM, checked on every clock.
module sync_burst_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cs1_n, cs2, cs3_n, astb_cpu_n, astb_ctl_n, adv_n;
    logic        wr_all_n, wr_byte_n, out_en_n, ilv_mode, sleep;
    logic [1:0]  byte_sel_n;
    logic [5:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic        rdata_drv;

    int    total = 0;
    int    bad = 0;
    string cur = "R9";

    // reference model state
    logic [15:0] mm [64];
    logic        m_s1v, m_s1w, m_qv, m_act, m_rd, m_ilv;
    logic [1:0]  m_s1be, m_cnt;
    logic [5:0]  m_s1a, m_base;
    logic [15:0] m_s1d, m_qd;

    sync_burst_sram dut_i (
        .clk(clk), .rst_n(rst_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .astb_cpu_n(astb_cpu_n), .astb_ctl_n(astb_ctl_n), .adv_n(adv_n),
        .wr_all_n(wr_all_n), .wr_byte_n(wr_byte_n), .byte_sel_n(byte_sel_n),
        .out_en_n(out_en_n), .ilv_mode(ilv_mode), .sleep(sleep), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_drv(rdata_drv)
    );

    always #10 clk = ~clk;

    function automatic logic [1:0] offs(input logic [1:0] s, input logic [1:0] k, input logic ilv);
        return ilv ? (s ^ k) : 2'((s + k) % 4);
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quiet();
        cs1_n = 0; cs2 = 1; cs3_n = 0; astb_cpu_n = 1; astb_ctl_n = 1; adv_n = 1;
        wr_all_n = 1; wr_byte_n = 1; byte_sel_n = 2'b11; out_en_n = 0; sleep = 0;
    endtask

    // Apply the current inputs for one clock, advance the model, check outputs.
    task automatic step();
        logic [1:0] be;
        logic       wr, strobe, sel, valid;
        logic [5:0] a;
        int         op; // 0 idle 1 sleep 2 desel 3 start 4 adv 5 hold
        @(posedge clk);
        if (m_s1v && m_s1w) begin
            if (m_s1be[0]) mm[m_s1a][7:0]  = m_s1d[7:0];
            if (m_s1be[1]) mm[m_s1a][15:8] = m_s1d[15:8];
        end
        if (m_s1v && !m_s1w) m_qd = mm[m_s1a];
        m_qv = !sleep && m_s1v && !m_s1w;
        be = !wr_all_n ? 2'b11 : (!wr_byte_n ? ~byte_sel_n : 2'b00);
        wr = |be;
        strobe = !astb_cpu_n || !astb_ctl_n;
        sel = !cs1_n && cs2 && !cs3_n;
        if (sleep)       op = 1;
        else if (strobe) op = sel ? 3 : 2;
        else if (m_act)  op = adv_n ? 5 : 4;
        else             op = 0;
        valid = (op == 3) || ((op == 4 || op == 5) && (wr || m_rd));
        a = m_base;
        if (op == 3) a = addr;
        if (op == 4) a = {m_base[5:2], offs(m_base[1:0], m_cnt + 2'd1, m_ilv)};
        if (op == 5) a = {m_base[5:2], offs(m_base[1:0], m_cnt, m_ilv)};
        if (op == 3) begin m_base = addr; m_cnt = 0; m_ilv = ilv_mode; m_act = 1; m_rd = !wr; end
        if (op == 4) begin m_cnt = m_cnt + 2'd1; if (wr) m_rd = 0; end
        if (op == 5 && wr) m_rd = 0;
        if (op == 1 || op == 2) begin m_act = 0; m_rd = 0; end
        m_s1v = valid; m_s1w = wr; m_s1be = be; m_s1a = a; m_s1d = wdata;
        @(negedge clk);
        check({cur, " drive"}, {15'd0, rdata_drv}, {15'd0, m_qv && !out_en_n});
        if (m_qv && !out_en_n) check({cur, " data"}, rdata, m_qd);
    endtask

    function automatic logic [15:0] pat(input int a);
        return 16'((a * 16'h0101) ^ 16'h5a3c);
    endfunction

    task automatic rd_start(input logic [5:0] a, input logic ctl, input logic ilv);
        quiet(); addr = a; ilv_mode = ilv;
        if (ctl) astb_ctl_n = 0; else astb_cpu_n = 0;
        step();
    endtask

    task automatic desel();
        quiet(); cs1_n = 1; astb_ctl_n = 0; step();
    endtask

    task automatic advance(input int n);
        for (int i = 0; i < n; i++) begin quiet(); adv_n = 0; step(); end
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL all requirements: watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        quiet(); ilv_mode = 1; addr = 0; wdata = 0; rst_n = 0;
        m_s1v = 0; m_s1w = 0; m_qv = 0; m_act = 0; m_rd = 0; m_ilv = 1;
        m_s1be = 0; m_cnt = 0; m_s1a = 0; m_base = 0; m_s1d = 0; m_qd = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        check("R9 reset drive", {15'd0, rdata_drv}, 16'd0);

        // R6: fill every word with global writes
        cur = "R6";
        for (int a = 0; a < 64; a++) begin
            quiet(); astb_ctl_n = 0; addr = 6'(a); wdata = pat(a);
            wr_all_n = 0; wr_byte_n = a[0]; byte_sel_n = 2'(a); step();
        end
        desel();

        // R3: single reads, alternating strobes, back-to-back
        cur = "R3";
        for (int a = 0; a < 64; a++) rd_start(6'(a), a[0], 1);
        desel();

        // R4 / R5: all start offsets in both orders, plus wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                cur = m ? "R4" : "R5";
                rd_start(6'(16 + s), 0, m[0]);
                advance(4);
                desel();
            end
        end

        // R7: full-width burst write via byte path with all selects low
        cur = "R7";
        quiet(); astb_cpu_n = 0; addr = 34; ilv_mode = 1;
        wr_byte_n = 0; byte_sel_n = 2'b00; wdata = 16'hc000; step();
        for (int i = 1; i < 4; i++) begin
            quiet(); adv_n = 0; wr_byte_n = 0; byte_sel_n = 2'b00; wdata = 16'(16'hc000 + i); step();
        end
        desel();
        rd_start(32, 1, 0); advance(3); desel();

        // R8: each byte-select pattern, then read back
        cur = "R8";
        for (int p = 0; p < 4; p++) begin
            quiet(); astb_ctl_n = 0; addr = 40; wr_byte_n = 0; byte_sel_n = 2'(p);
            wdata = 16'(16'ha5a5 ^ (p * 16'h1111)); step();
            desel();
            rd_start(40, 0, 1); desel();
        end

        // R1: all select combinations on a strobe read
        cur = "R1";
        for (int c = 0; c < 8; c++) begin
            quiet(); cs1_n = c[2]; cs2 = c[1]; cs3_n = c[0]; astb_ctl_n = 0; addr = 6'(5 + c); step();
            quiet(); step();
            desel();
        end

        // R2: burst keeps stepping with deselect pattern on selects
        cur = "R2";
        rd_start(12, 0, 0);
        for (int i = 0; i < 3; i++) begin
            quiet(); cs1_n = 1; cs2 = 0; cs3_n = 1; adv_n = 0; step();
        end
        desel();

        // R9: output enable gating and quiet bus after a write
        cur = "R9";
        rd_start(7, 0, 1); out_en_n = 1; step();
        quiet(); out_en_n = 1; step();
        quiet(); step();
        quiet(); step();
        quiet(); astb_cpu_n = 0; addr = 9; wr_all_n = 0; wdata = 16'h1234; step();
        quiet(); step();
        quiet(); step();
        rd_start(9, 0, 1);
        quiet(); astb_ctl_n = 0; addr = 9; wr_all_n = 0; wdata = 16'h4321; step();
        rd_start(9, 1, 1);
        desel();

        // R10: strobe with advance low reloads; hold repeats
        cur = "R10";
        rd_start(20, 0, 1); advance(1);
        quiet(); astb_ctl_n = 0; adv_n = 0; addr = 44; step();
        quiet(); step();
        quiet(); step();
        advance(1);
        desel();

        // R11: sleep ignores writes, quiet bus before and after exit
        cur = "R11";
        desel();
        quiet(); sleep = 1; step();
        quiet(); sleep = 1; astb_ctl_n = 0; addr = 3; wr_all_n = 0; wdata = 16'hdead; step();
        quiet(); sleep = 1; astb_cpu_n = 0; addr = 3; step();
        quiet(); step();
        quiet(); step();
        rd_start(3, 0, 1);
        desel();
        quiet(); step();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule